// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles where execution goes after a branch instruction of a 32-bit RISC core. For each issued branch it takes the decoded fields: the form, a 5-bit options field, a 5-bit condition-bit index, a displacement, and the absolute and link flags. It also takes the current instruction address and the condition, count and link registers. From these it returns the next instruction address, whether the branch was taken, the new count register value, and an optional link register write.

One options field drives three things together. It decides whether the counter is decremented, whether and how the counter is tested for zero, and whether a selected condition bit is tested and against which polarity. The branch is taken only if the counter test and the condition test both pass. Results are registered, so they appear one clock after the branch is issued.

Top module: `brn_resolve_unit`

## Requirements
- R1: When options bit 2 (weight 4) is clear, the count result is the count input minus one, wrapping from 0 to all ones. When that bit is set, the count result equals the count input.
- R2: The counter test passes when options bit 2 is set. Otherwise it passes when (decremented count is non-zero) XOR options bit 3 (weight 8) is true.
- R3: The condition test passes when options bit 4 (weight 16) is set. Otherwise it passes when the selected condition bit equals options bit 1 (weight 2). Index i selects condition register bit 31−i, so index 0 selects the most significant bit.
- R4: The branch is taken if and only if both the counter test and the condition test pass.
- R5: For the immediate and conditional forms, a target is used as the address when the absolute flag is 1. When the flag is 0, the target is added to the current address.
- R6: When the link flag is 1, the link write enable is asserted and the link value is the current address plus 4, whether or not the branch is taken. When the link flag is 0, no link write is made.
- R7: The immediate form (form code 0) always behaves as options value 0x1F: it is always taken and never decrements. Its target is the 24-bit displacement shifted left by 2 and sign-extended from 26 bits.
- R8: The conditional form (form code 1) uses the low 14 displacement bits, shifted left by 2 and sign-extended to 32 bits. The upper displacement bits are ignored.
- R9: The to-link form (code 2) and the to-count form (code 3) branch to the link or count register value as an absolute address, whatever the absolute flag says. The to-count form uses the count value from before any decrement.
- R10: When the branch is not taken, the next address is the current address plus 4.
- R11: All results appear on the clock edge after an issue cycle (valid in high). The valid output follows the valid input with one cycle of delay. In idle cycles the address, taken and count outputs hold and no link write is made. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Branch issued this cycle |
| form_i | input | 2 | 0 immediate, 1 conditional, 2 to-link, 3 to-count |
| cia_i | input | 32 | Current instruction address |
| opts_i | input | 5 | Branch options field |
| cbit_i | input | 5 | Condition bit index, counted from the MSB |
| disp_i | input | 24 | Displacement (conditional form uses low 14 bits) |
| abs_i | input | 1 | Target is absolute |
| link_i | input | 1 | Write return address to link register |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 32 | Count register |
| lr_i | input | 32 | Link register |
| valid_o | output | 1 | Results valid |
| taken_o | output | 1 | Branch taken |
| nia_o | output | 32 | Next instruction address |
| ctr_o | output | 32 | Updated count register |
| lr_we_o | output | 1 | Link register write enable |
| lr_o | output | 32 | Link register write value |

## Verification
The bench uses the default parameters: a 32-bit datapath, a 32-bit condition register, a 24-bit immediate displacement and a 14-bit conditional displacement. With these values it can reach the sign bits at 26 and 16 bits and both ends of the condition register index. It can also reach the count wrap from zero to all ones and the case where the count decrements to exactly zero, where the counter test flips with options bit 3.

// File: rtl/brn_pkg.sv
package brn_pkg;
  typedef enum logic [1:0] {
    FORM_IMM     = 2'd0,
    FORM_COND    = 2'd1,
    FORM_TO_LINK = 2'd2,
    FORM_TO_CNT  = 2'd3
  } brn_form_e;

  localparam int unsigned OPT_W        = 5;
  localparam int unsigned OPT_POL_BIT  = 1;
  localparam int unsigned OPT_NODEC    = 2;
  localparam int unsigned OPT_ZERO_BIT = 3;
  localparam int unsigned OPT_NOCOND   = 4;
  localparam logic [OPT_W-1:0] OPT_ALWAYS = 5'h1F;
endpackage

// File: rtl/brn_cond_eval.sv
module brn_cond_eval
  import brn_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned CR_W  = 32,
  localparam int unsigned IDX_W = $clog2(CR_W)
) (
  input  brn_form_e        form_i,
  input  logic [OPT_W-1:0] opts_i,
  input  logic [IDX_W-1:0] cbit_i,
  input  logic [CR_W-1:0]  cr_i,
  input  logic [XLEN-1:0]  ctr_i,
  output logic [XLEN-1:0]  ctr_next_o,
  output logic             taken_o
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CR_W - 1);

  logic [OPT_W-1:0] eff_opts;
  logic [IDX_W-1:0] sel_idx;
  logic             cnt_ok, cond_ok;

  // immediate form ignores the field and always branches
  assign eff_opts   = (form_i == FORM_IMM) ? OPT_ALWAYS : opts_i;
  assign ctr_next_o = eff_opts[OPT_NODEC] ? ctr_i : ctr_i - XLEN'(1);
  assign sel_idx    = TOP_IDX - cbit_i;

  always_comb begin
    cnt_ok  = eff_opts[OPT_NODEC] | ((ctr_next_o != '0) ^ eff_opts[OPT_ZERO_BIT]);
    cond_ok = eff_opts[OPT_NOCOND] | (cr_i[sel_idx] == eff_opts[OPT_POL_BIT]);
  end

  assign taken_o = cnt_ok & cond_ok;
endmodule

// File: rtl/brn_target_gen.sv
module brn_target_gen
  import brn_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned LI_W       = 24,
  parameter int unsigned BD_W       = 14,
  parameter int unsigned INSN_BYTES = 4
) (
  input  brn_form_e       form_i,
  input  logic [LI_W-1:0] disp_i,
  input  logic            abs_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic [XLEN-1:0] ctr_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] nia_o
);
  logic [XLEN-1:0] li_ext, bd_ext, off, rel_tgt, tgt;

  assign li_ext  = {{(XLEN-LI_W-2){disp_i[LI_W-1]}}, disp_i, 2'b00};
  assign bd_ext  = {{(XLEN-BD_W-2){disp_i[BD_W-1]}}, disp_i[BD_W-1:0], 2'b00};
  assign off     = (form_i == FORM_IMM) ? li_ext : bd_ext;
  assign rel_tgt = abs_i ? off : cia_i + off;
  assign seq_o   = cia_i + XLEN'(INSN_BYTES);

  always_comb begin
    unique case (form_i)
      FORM_TO_LINK: tgt = lr_i;
      FORM_TO_CNT:  tgt = ctr_i;   // pre-decrement value
      default:      tgt = rel_tgt;
    endcase
  end

  assign nia_o = taken_i ? tgt : seq_o;
endmodule

// File: rtl/brn_resolve_unit.sv
module brn_resolve_unit
  import brn_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned CR_W       = 32,
  parameter int unsigned LI_W       = 24,
  parameter int unsigned BD_W       = 14,
  parameter int unsigned INSN_BYTES = 4,
  localparam int unsigned IDX_W     = $clog2(CR_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       form_i,
  input  logic [XLEN-1:0]  cia_i,
  input  logic [OPT_W-1:0] opts_i,
  input  logic [IDX_W-1:0] cbit_i,
  input  logic [LI_W-1:0]  disp_i,
  input  logic             abs_i,
  input  logic             link_i,
  input  logic [CR_W-1:0]  cr_i,
  input  logic [XLEN-1:0]  ctr_i,
  input  logic [XLEN-1:0]  lr_i,
  output logic             valid_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  nia_o,
  output logic [XLEN-1:0]  ctr_o,
  output logic             lr_we_o,
  output logic [XLEN-1:0]  lr_o
);
  brn_form_e       form;
  logic [XLEN-1:0] ctr_next, nia_next, seq_addr;
  logic            taken;

  assign form = brn_form_e'(form_i);

  brn_cond_eval #(.XLEN(XLEN), .CR_W(CR_W)) u_cond (
    .form_i     (form),
    .opts_i     (opts_i),
    .cbit_i     (cbit_i),
    .cr_i       (cr_i),
    .ctr_i      (ctr_i),
    .ctr_next_o (ctr_next),
    .taken_o    (taken)
  );

  brn_target_gen #(.XLEN(XLEN), .LI_W(LI_W), .BD_W(BD_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .form_i  (form),
    .disp_i  (disp_i),
    .abs_i   (abs_i),
    .taken_i (taken),
    .cia_i   (cia_i),
    .lr_i    (lr_i),
    .ctr_i   (ctr_i),
    .seq_o   (seq_addr),
    .nia_o   (nia_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      taken_o <= 1'b0;
      nia_o   <= '0;
      ctr_o   <= '0;
      lr_we_o <= 1'b0;
      lr_o    <= '0;
    end else begin
      valid_o <= valid_i;
      lr_we_o <= valid_i & link_i;
      if (valid_i) begin
        taken_o <= taken;
        nia_o   <= nia_next;
        ctr_o   <= ctr_next;
        if (link_i) lr_o <= seq_addr;
      end
    end
  end
endmodule

// File: rtl/brn_resolve_unit_chk.sv
module brn_resolve_unit_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OPT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       form_i,
  input logic [XLEN-1:0]  cia_i,
  input logic [OPT_W-1:0] opts_i,
  input logic             link_i,
  input logic [XLEN-1:0]  ctr_i,
  input logic             valid_o,
  input logic             taken_o,
  input logic [XLEN-1:0]  nia_o,
  input logic [XLEN-1:0]  ctr_o,
  input logic             lr_we_o,
  input logic [XLEN-1:0]  lr_o
);
  a_r1_ctr_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i != 2'd0 && !opts_i[2] |=> ctr_o == $past(ctr_i) - XLEN'(1));

  a_r1_ctr_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (form_i == 2'd0 || opts_i[2]) |=> ctr_o == $past(ctr_i));

  a_r6_link_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && link_i |=> lr_we_o && lr_o == $past(cia_i) + XLEN'(4));

  a_r6_no_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && link_i) |=> !lr_we_o);

  a_r7_imm_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i == 2'd0 |=> taken_o);

  a_r9_to_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i == 2'd3 |=> (!taken_o || nia_o == $past(ctr_i)));

  a_r10_fall_thru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (taken_o || nia_o == $past(cia_i) + XLEN'(4)));

  a_r11_valid_pipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i) || !$past(rst_ni));

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(nia_o) && $stable(ctr_o) && $stable(taken_o));
endmodule

bind brn_resolve_unit brn_resolve_unit_chk #(.XLEN(XLEN), .OPT_W(brn_pkg::OPT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .form_i  (form_i),
  .cia_i   (cia_i),
  .opts_i  (opts_i),
  .link_i  (link_i),
  .ctr_i   (ctr_i),
  .valid_o (valid_o),
  .taken_o (taken_o),
  .nia_o   (nia_o),
  .ctr_o   (ctr_o),
  .lr_we_o (lr_we_o),
  .lr_o    (lr_o)
);

// File: tb/brn_resolve_unit_tb.sv
module brn_resolve_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  form_i = '0;
  logic [31:0] cia_i = '0;
  logic [4:0]  opts_i = '0;
  logic [4:0]  cbit_i = '0;
  logic [23:0] disp_i = '0;
  logic        abs_i = 1'b0;
  logic        link_i = 1'b0;
  logic [31:0] cr_i = '0;
  logic [31:0] ctr_i = '0;
  logic [31:0] lr_i = '0;
  logic        valid_o, taken_o, lr_we_o;
  logic [31:0] nia_o, ctr_o, lr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  brn_resolve_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .form_i(form_i),
    .cia_i(cia_i), .opts_i(opts_i), .cbit_i(cbit_i), .disp_i(disp_i),
    .abs_i(abs_i), .link_i(link_i), .cr_i(cr_i), .ctr_i(ctr_i), .lr_i(lr_i),
    .valid_o(valid_o), .taken_o(taken_o), .nia_o(nia_o), .ctr_o(ctr_o),
    .lr_we_o(lr_we_o), .lr_o(lr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // issue one branch, return at the negedge after the result register loads
  task automatic issue(input logic [1:0] f, input logic [4:0] o, input logic [4:0] cb,
                       input logic [23:0] d, input logic ab, input logic lk,
                       input logic [31:0] cr, input logic [31:0] ct, input logic [31:0] lr);
    @(negedge clk);
    valid_i = 1'b1; form_i = f; opts_i = o; cbit_i = cb; disp_i = d;
    abs_i = ab; link_i = lk; cr_i = cr; ctr_i = ct; lr_i = lr; cia_i = 32'h1000;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic tk, input logic [31:0] nia,
                            input logic [31:0] ct);
    chk({tag, " valid"}, {31'd0, valid_o}, 32'd1);
    chk({tag, " taken"}, {31'd0, taken_o}, {31'd0, tk});
    chk({tag, " nia"}, nia_o, nia);
    chk({tag, " ctr"}, ctr_o, ct);
  endtask

  task automatic t_reset;
    chk("R11 reset valid", {31'd0, valid_o}, 32'd0);
    chk("R11 reset nia", nia_o, 32'd0);
    chk("R11 reset ctr", ctr_o, 32'd0);
    chk("R11 reset lr_we", {31'd0, lr_we_o}, 32'd0);
  endtask

  task automatic t_immediate;
    // R7: opts field ignored (0 given), ctr untouched
    issue(2'd0, 5'h00, 5'd0, 24'h000010, 1'b0, 1'b0, 32'h0, 32'h55, 32'h0);
    expect_res("R7 imm rel", 1'b1, 32'h1040, 32'h55);
    issue(2'd0, 5'h00, 5'd0, 24'hFFFFFC, 1'b0, 1'b0, 32'h0, 32'h55, 32'h0);
    expect_res("R7 imm neg rel", 1'b1, 32'h0FF0, 32'h55);
    issue(2'd0, 5'h00, 5'd0, 24'hFFFFFF, 1'b1, 1'b0, 32'h0, 32'h55, 32'h0);
    expect_res("R5 imm abs", 1'b1, 32'hFFFF_FFFC, 32'h55);
  endtask

  task automatic t_counter;
    issue(2'd1, 5'b10000, 5'd0, 24'h000008, 1'b0, 1'b0, 32'h0, 32'd5, 32'h0);
    expect_res("R2 dec nz taken", 1'b1, 32'h1020, 32'd4);
    issue(2'd1, 5'b10000, 5'd0, 24'h000008, 1'b0, 1'b0, 32'h0, 32'd1, 32'h0);
    expect_res("R10 dec to zero falls", 1'b0, 32'h1004, 32'd0);
    issue(2'd1, 5'b11000, 5'd0, 24'h000008, 1'b0, 1'b0, 32'h0, 32'd1, 32'h0);
    expect_res("R2 zero test taken", 1'b1, 32'h1020, 32'd0);
    issue(2'd1, 5'b11000, 5'd0, 24'h000008, 1'b0, 1'b0, 32'h0, 32'd0, 32'h0);
    expect_res("R1 wrap not taken", 1'b0, 32'h1004, 32'hFFFF_FFFF);
  endtask

  task automatic t_condition;
    issue(2'd1, 5'b00110, 5'd0, 24'h000008, 1'b0, 1'b0, 32'h8000_0000, 32'd7, 32'h0);
    expect_res("R3 msb set taken", 1'b1, 32'h1020, 32'd7);
    issue(2'd1, 5'b00110, 5'd0, 24'h000008, 1'b0, 1'b0, 32'h0000_0001, 32'd7, 32'h0);
    expect_res("R3 msb clear falls", 1'b0, 32'h1004, 32'd7);
    issue(2'd1, 5'b00110, 5'd31, 24'h000008, 1'b0, 1'b0, 32'h0000_0001, 32'd7, 32'h0);
    expect_res("R3 idx31 lsb taken", 1'b1, 32'h1020, 32'd7);
    issue(2'd1, 5'b00100, 5'd31, 24'h000008, 1'b0, 1'b0, 32'h0000_0001, 32'd7, 32'h0);
    expect_res("R3 pol0 falls", 1'b0, 32'h1004, 32'd7);
    issue(2'd1, 5'b00100, 5'd31, 24'h000008, 1'b0, 1'b0, 32'hFFFF_FFFE, 32'd7, 32'h0);
    expect_res("R3 pol0 taken", 1'b1, 32'h1020, 32'd7);
  endtask

  task automatic t_both;
    issue(2'd1, 5'b00010, 5'd4, 24'h000008, 1'b0, 1'b0, 32'h0800_0000, 32'd3, 32'h0);
    expect_res("R4 both pass", 1'b1, 32'h1020, 32'd2);
    issue(2'd1, 5'b00010, 5'd4, 24'h000008, 1'b0, 1'b0, 32'h0800_0000, 32'd1, 32'h0);
    expect_res("R4 cnt fails", 1'b0, 32'h1004, 32'd0);
    issue(2'd1, 5'b00010, 5'd4, 24'h000008, 1'b0, 1'b0, 32'h0, 32'd3, 32'h0);
    expect_res("R4 cond fails", 1'b0, 32'h1004, 32'd2);
  endtask

  task automatic t_cond_disp;
    // upper bits 23:14 are junk and must be ignored
    issue(2'd1, 5'b10100, 5'd0, 24'hABFFFF, 1'b0, 1'b0, 32'h0, 32'd9, 32'h0);
    expect_res("R8 neg disp", 1'b1, 32'h0FFC, 32'd9);
    issue(2'd1, 5'b10100, 5'd0, 24'h000100, 1'b1, 1'b0, 32'h0, 32'd9, 32'h0);
    expect_res("R5 cond abs", 1'b1, 32'h0000_0400, 32'd9);
    issue(2'd1, 5'b10100, 5'd0, 24'h002000, 1'b0, 1'b0, 32'h0, 32'd9, 32'h0);
    expect_res("R8 min disp", 1'b1, 32'h1000 - 32'h8000, 32'd9);
  endtask

  task automatic t_reg_targets;
    issue(2'd2, 5'b10100, 5'd0, 24'h000000, 1'b0, 1'b1, 32'h0, 32'd9, 32'h2000);
    expect_res("R9 to-link", 1'b1, 32'h2000, 32'd9);
    chk("R6 link we", {31'd0, lr_we_o}, 32'd1);
    chk("R6 link val", lr_o, 32'h1004);
    issue(2'd3, 5'b10100, 5'd0, 24'h000040, 1'b0, 1'b0, 32'h0, 32'h3000, 32'h2000);
    expect_res("R9 to-cnt", 1'b1, 32'h3000, 32'h3000);
    issue(2'd3, 5'b10000, 5'd0, 24'h000040, 1'b0, 1'b0, 32'h0, 32'h3000, 32'h2000);
    expect_res("R9 to-cnt predec", 1'b1, 32'h3000, 32'h2FFF);
  endtask

  task automatic t_link_not_taken;
    issue(2'd1, 5'b00110, 5'd0, 24'h000008, 1'b0, 1'b1, 32'h0, 32'd7, 32'h0);
    expect_res("R6 link on fall", 1'b0, 32'h1004, 32'd7);
    chk("R6 link we fall", {31'd0, lr_we_o}, 32'd1);
    chk("R6 link val fall", lr_o, 32'h1004);
    issue(2'd1, 5'b10100, 5'd0, 24'h000008, 1'b0, 1'b0, 32'h0, 32'd7, 32'h0);
    chk("R6 no link we", {31'd0, lr_we_o}, 32'd0);
  endtask

  task automatic t_idle;
    issue(2'd0, 5'h00, 5'd0, 24'h000010, 1'b0, 1'b0, 32'h0, 32'h77, 32'h0);
    @(negedge clk);
    ctr_i = 32'h1234; cia_i = 32'h8000; link_i = 1'b1; disp_i = 24'h000100;
    @(negedge clk);
    chk("R11 idle valid", {31'd0, valid_o}, 32'd0);
    chk("R11 idle nia", nia_o, 32'h1040);
    chk("R11 idle ctr", ctr_o, 32'h77);
    chk("R11 idle lr_we", {31'd0, lr_we_o}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_immediate();
    t_counter();
    t_condition();
    t_both();
    t_cond_disp();
    t_reg_targets();
    t_link_not_taken();
    t_idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule